// File: doc/BRIEF.md
# Word-Coherent Shared RAM Writer

This block owns a byte-wide RAM buffer that two masters share: a CPU write/read port and the DMA port of a serial slave engine. The CPU can update a 16-bit value as two separate byte writes. The DMA side never observes the state where one byte of the pair is new and the other is old.

The CPU arms word mode through a small control register. The next CPU byte written to an even address inside the permitted zone is parked in a shadow register, and RAM is left untouched. The following write to the odd neighbour goes straight to RAM. On the next cycle the parked byte is committed to the even address. During that commit cycle the DMA grant is withheld. Hardware then disarms word mode, so the CPU must arm it again before each update.

Pairs written by the DMA side get no such protection. Their bytes land in RAM as they arrive.

Top module: `wordsafe_ram_writer`

## Requirements
- R1: After reset the control register reads 0x00: bit 0 (word select) is 0, bit 1 (busy) is 0 and bit 2 (error) is 0. The block is in byte mode.
- R2: A control write loads bit 0 into word select and always sets busy, whatever value bit 1 carries. Writing a 0 in bit 1 never clears busy. Word mode is armed when both word select and busy are 1.
- R3: When word mode is not armed, a CPU write lands in RAM at its address and can be read back on the next cycle.
- R4: When word mode is armed and no byte is parked, a CPU write to an even address in the zone is held in the shadow register and RAM keeps its old contents. With default parameters the zone covers 0x10 to 0x3F inclusive, which is the buffers of slaves 1 to 3 at 16 bytes each.
- R5: While a byte is parked, a CPU write to the parked address plus one is written to RAM directly at its clock edge.
- R6: On the cycle after that odd write, the parked byte is written to the even address. From the following cycle both bytes read back with their new values.
- R7: dma_gnt equals dma_req except in the commit cycle, when it is 0. A request that is held through the commit cycle is granted on the next cycle.
- R8: The commit clears both word select and busy. The next CPU write goes to RAM directly.
- R9: When word mode is armed and no byte is parked, a CPU write to an odd address or to an address outside the zone goes to RAM directly and sets the error bit. The error bit stays set until a control write with bit 2 equal to 1.
- R10: A granted DMA write with dma_we=1 lands in RAM at dma_addr. dma_rdata always shows the RAM contents at dma_addr.
- R11: Zone edges: even addresses 0x10 and 0x3E are captured, while 0x0E and 0x40 are rejected under R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data (bit0 select, bit2=1 clears error) |
| ctrl_rdata | output | 8 | Control readback {5'b0, error, busy, select} |
| cpu_we | input | 1 | CPU byte write strobe |
| cpu_addr | input | AW | CPU address for write and read |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | RAM byte at cpu_addr |
| dma_req | input | 1 | DMA access request |
| dma_we | input | 1 | DMA access is a write |
| dma_addr | input | AW | DMA address |
| dma_wdata | input | 8 | DMA write byte |
| dma_gnt | output | 1 | DMA access granted this cycle |
| dma_rdata | output | 8 | RAM byte at dma_addr |

## Verification
The hardest state to reach is the commit cycle. In that cycle the odd byte is already in RAM, the even byte is still old, and a DMA request is pending. It lasts exactly one clock and only exists after an arm, a capture and a matching odd write. The stimulus raises dma_req at the negative edge that follows the odd write. It then reads the even address through the DMA read port to confirm the old value, checks that the grant is held off, and one cycle later sees the grant and the new word together.

// File: rtl/wsw_pkg.sv
package wsw_pkg;
  // Address lies in the buffers of slaves 1..NSLV-1 (slave 0 excluded).
  function automatic logic in_word_zone(input int unsigned addr,
                                        input int unsigned base,
                                        input int unsigned len,
                                        input int unsigned nslv);
    return (addr >= base + len) && (addr < base + nslv * len);
  endfunction

  // Second address of a coherent pair.
  function automatic int unsigned pair_of(input int unsigned even_addr);
    return even_addr + 1;
  endfunction

  // Control readback layout.
  function automatic logic [7:0] pack_ctrl(input logic sel, input logic busy,
                                           input logic err);
    return {5'b0, err, busy, sel};
  endfunction
endpackage

// File: rtl/wsw_ctrl.sv
module wsw_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  input  logic       done,
  input  logic       set_err,
  output logic       word_sel,
  output logic       busy_w,
  output logic       err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_sel <= 1'b0;
      busy_w   <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (ctrl_we) begin
        word_sel <= ctrl_wdata[0];
        busy_w   <= 1'b1;
        if (ctrl_wdata[2]) err <= 1'b0;
      end
      if (set_err) err <= 1'b1;
      if (done) begin
        word_sel <= 1'b0;
        busy_w   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wsw_shadow.sv
module wsw_shadow #(
  parameter int AW        = 8,
  parameter int ZONE_BASE = 0,
  parameter int ZONE_LEN  = 16,
  parameter int NSLV      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic          capture,
  output logic          pair_hit,
  output logic          bypass_err,
  output logic          cpu_ram_we,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic [7:0]    commit_data
);
  import wsw_pkg::*;

  logic          parked;
  logic [AW-1:0] sh_addr;
  logic [7:0]    sh_data;
  logic          zone_ok;
  logic          open_arm;
  logic [AW-1:0] pair_addr;

  assign zone_ok   = in_word_zone(int'(cpu_addr), ZONE_BASE, ZONE_LEN, NSLV) && !cpu_addr[0];
  assign open_arm  = armed && !commit && !parked;
  assign pair_addr = AW'(pair_of(int'(sh_addr)));

  assign capture    = open_arm && cpu_we && zone_ok;
  assign bypass_err = open_arm && cpu_we && !zone_ok;
  assign pair_hit   = parked && cpu_we && (cpu_addr == pair_addr);
  assign cpu_ram_we = cpu_we && !capture;

  assign commit_addr = sh_addr;
  assign commit_data = sh_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parked  <= 1'b0;
      sh_addr <= '0;
      sh_data <= '0;
      commit  <= 1'b0;
    end else begin
      commit <= pair_hit;
      if (capture) begin
        parked  <= 1'b1;
        sh_addr <= cpu_addr;
        sh_data <= cpu_wdata;
      end else if (pair_hit || !armed) begin
        parked <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wsw_ram.sv
module wsw_ram #(
  parameter int AW = 8,
  parameter int NP = 3
) (
  input  logic                 clk,
  input  logic [NP-1:0]        we,
  input  logic [NP-1:0][AW-1:0] waddr,
  input  logic [NP-1:0][7:0]   wdata,
  input  logic [AW-1:0]        raddr_a,
  input  logic [AW-1:0]        raddr_b,
  output logic [7:0]           rdata_a,
  output logic [7:0]           rdata_b
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  // Higher port index wins on a same-address collision.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (we[p]) mem[waddr[p]] <= wdata[p];
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/wordsafe_ram_writer.sv
module wordsafe_ram_writer #(
  parameter int AW        = 8,
  parameter int ZONE_BASE = 0,
  parameter int ZONE_LEN  = 16,
  parameter int NSLV      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic [7:0]    ctrl_wdata,
  output logic [7:0]    ctrl_rdata,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  input  logic          dma_req,
  input  logic          dma_we,
  input  logic [AW-1:0] dma_addr,
  input  logic [7:0]    dma_wdata,
  output logic          dma_gnt,
  output logic [7:0]    dma_rdata
);
  import wsw_pkg::*;

  localparam int NPORT  = 3;
  localparam int P_DMA  = 0;
  localparam int P_CPU  = 1;
  localparam int P_CMT  = 2;

  logic          word_sel, busy_w, err, armed;
  logic          capture, pair_hit, bypass_err, cpu_ram_we, commit;
  logic [AW-1:0] commit_addr;
  logic [7:0]    commit_data;

  logic [NPORT-1:0]         ram_we;
  logic [NPORT-1:0][AW-1:0] ram_waddr;
  logic [NPORT-1:0][7:0]    ram_wdata;

  assign armed = word_sel && busy_w;

  wsw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .done(commit), .set_err(bypass_err),
    .word_sel(word_sel), .busy_w(busy_w), .err(err)
  );

  wsw_shadow #(.AW(AW), .ZONE_BASE(ZONE_BASE), .ZONE_LEN(ZONE_LEN), .NSLV(NSLV)) u_shadow (
    .clk(clk), .rst_n(rst_n), .armed(armed),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .capture(capture), .pair_hit(pair_hit), .bypass_err(bypass_err),
    .cpu_ram_we(cpu_ram_we), .commit(commit),
    .commit_addr(commit_addr), .commit_data(commit_data)
  );

  assign dma_gnt = dma_req && !commit;

  assign ram_we[P_DMA]    = dma_gnt && dma_we;
  assign ram_waddr[P_DMA] = dma_addr;
  assign ram_wdata[P_DMA] = dma_wdata;
  assign ram_we[P_CPU]    = cpu_ram_we;
  assign ram_waddr[P_CPU] = cpu_addr;
  assign ram_wdata[P_CPU] = cpu_wdata;
  assign ram_we[P_CMT]    = commit;
  assign ram_waddr[P_CMT] = commit_addr;
  assign ram_wdata[P_CMT] = commit_data;

  wsw_ram #(.AW(AW), .NP(NPORT)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr_a(cpu_addr), .raddr_b(dma_addr),
    .rdata_a(cpu_rdata), .rdata_b(dma_rdata)
  );

  assign ctrl_rdata = pack_ctrl(word_sel, busy_w, err);
endmodule

// File: rtl/wsw_checker.sv
module wsw_checker (
  input logic clk,
  input logic rst_n,
  input logic ctrl_we,
  input logic commit,
  input logic capture,
  input logic pair_hit,
  input logic bypass_err,
  input logic cpu_ram_we,
  input logic dma_req,
  input logic dma_gnt,
  input logic word_sel,
  input logic busy_w,
  input logic err
);
  // R2
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !commit) |=> busy_w);
  // R4
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !cpu_ram_we);
  // R6
  commit_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_hit |=> commit);
  // R7
  dma_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !dma_gnt);
  // R7
  dma_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(commit) && dma_req) |-> dma_gnt);
  // R8
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (!word_sel && !busy_w));
  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_err |=> err);
endmodule

bind wordsafe_ram_writer wsw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .commit(commit),
  .capture(capture), .pair_hit(pair_hit), .bypass_err(bypass_err),
  .cpu_ram_we(cpu_ram_we), .dma_req(dma_req), .dma_gnt(dma_gnt),
  .word_sel(word_sel), .busy_w(busy_w), .err(err)
);

// File: tb/wordsafe_ram_writer_test.sv
module wordsafe_ram_writer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic [7:0] ctrl_rdata;
  logic       cpu_we = 1'b0;
  logic [7:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       dma_req = 1'b0;
  logic       dma_we = 1'b0;
  logic [7:0] dma_addr = '0;
  logic [7:0] dma_wdata = '0;
  logic       dma_gnt;
  logic [7:0] dma_rdata;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  wordsafe_ram_writer uut (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
    .dma_gnt(dma_gnt), .dma_rdata(dma_rdata)
  );

  // {address, data} written in byte mode, then read back.
  localparam logic [15:0] BYTE_VEC [8] = '{
    16'h20AA, 16'h21BB, 16'h3E00, 16'h3F01,
    16'h10C0, 16'h11C1, 16'h055A, 16'hFFF0
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic ctrl_wr(input logic [7:0] d);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    dma_addr = a;
    #1;
    d = dma_rdata;
  endtask

  task automatic expect_mem(input logic [7:0] a, input logic [7:0] e, input string tag);
    logic [7:0] v;
    peek(a, v);
    chk(v === e, tag, int'(v), int'(e));
  endtask

  task automatic expect_ctrl(input logic [7:0] e, input string tag);
    #1;
    chk(ctrl_rdata === e, tag, int'(ctrl_rdata), int'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_ctrl(8'h00, "R1 reset control");

    // R3: byte-mode writes from the vector table
    foreach (BYTE_VEC[i]) begin
      cpu_wr(BYTE_VEC[i][15:8], BYTE_VEC[i][7:0]);
      expect_mem(BYTE_VEC[i][15:8], BYTE_VEC[i][7:0], "R3 byte mode write");
    end

    // R2: bit1=0 still sets busy; select follows bit0
    ctrl_wr(8'h00);
    expect_ctrl(8'h02, "R2 busy set by any write");
    ctrl_wr(8'h01);
    expect_ctrl(8'h03, "R2 armed");

    // R4: capture
    cpu_wr(8'h20, 8'h11);
    expect_mem(8'h20, 8'hAA, "R4 first byte held");
    // R5: odd byte goes to RAM; now in commit cycle
    cpu_wr(8'h21, 8'h22);
    dma_req = 1'b1;
    expect_mem(8'h21, 8'h22, "R5 odd byte written");
    expect_mem(8'h20, 8'hAA, "R6 even not yet committed");
    chk(dma_gnt === 1'b0, "R7 grant blocked in commit", int'(dma_gnt), 0);
    @(negedge clk);
    #1;
    chk(dma_gnt === 1'b1, "R7 held request granted", int'(dma_gnt), 1);
    expect_mem(8'h20, 8'h11, "R6 commit of shadow byte");
    dma_req = 1'b0;
    expect_ctrl(8'h00, "R8 disarmed after commit");

    // R8: next write goes straight through
    cpu_wr(8'h30, 8'h55);
    expect_mem(8'h30, 8'h55, "R8 byte mode resumes");

    // R9: odd address while armed
    ctrl_wr(8'h01);
    cpu_wr(8'h23, 8'h66);
    expect_mem(8'h23, 8'h66, "R9 odd first byte direct");
    expect_ctrl(8'h07, "R9 error sticky set");
    // R11: 0x40 rejected
    cpu_wr(8'h40, 8'h67);
    expect_mem(8'h40, 8'h67, "R11 0x40 direct");
    ctrl_wr(8'h04);
    expect_ctrl(8'h02, "R9 error cleared");

    // R11: 0x0E rejected
    ctrl_wr(8'h01);
    cpu_wr(8'h0E, 8'h12);
    expect_mem(8'h0E, 8'h12, "R11 0x0E direct");
    expect_ctrl(8'h07, "R11 0x0E flags error");
    ctrl_wr(8'h04);

    // R11: 0x3E captured
    ctrl_wr(8'h01);
    cpu_wr(8'h3E, 8'h77);
    expect_mem(8'h3E, 8'h00, "R11 0x3E captured");
    cpu_wr(8'h3F, 8'h78);
    @(negedge clk);
    expect_mem(8'h3E, 8'h77, "R11 0x3E committed");
    expect_mem(8'h3F, 8'h78, "R11 0x3F written");

    // R11: 0x10 captured
    ctrl_wr(8'h01);
    cpu_wr(8'h10, 8'h99);
    expect_mem(8'h10, 8'hC0, "R11 0x10 captured");
    cpu_wr(8'h11, 8'h9A);
    @(negedge clk);
    expect_mem(8'h10, 8'h99, "R11 0x10 committed");
    expect_ctrl(8'h00, "R8 disarmed again");

    // R10: DMA write lands directly
    @(negedge clk);
    dma_req = 1'b1; dma_we = 1'b1; dma_addr = 8'h50; dma_wdata = 8'h9C;
    #1;
    chk(dma_gnt === 1'b1, "R7 grant follows request", int'(dma_gnt), 1);
    @(negedge clk);
    dma_req = 1'b0; dma_we = 1'b0;
    expect_mem(8'h50, 8'h9C, "R10 DMA write");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule